// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets on-chip logic reach an external asynchronous static RAM of 64K words by 16 bits through a simple request port. A requester presents an address, write data, a per-byte lane mask and a read/write flag under a valid/ready handshake. The controller then sequences the memory's active-low select, write, output and byte-lane strobes. All strobes come from registers, so the glitch-free edges at the pins mark the write window and the read sampling point. Read data returns on a separate port with a one-cycle valid pulse.

The memory's timing figures are converted into clock-cycle counts through parameters: the read access window, the write pulse width and the power-up wait. The data pins are handled as a split output value, output enable and input value. The pad cell that merges them into one bidirectional bus sits outside the block.

Top module: `lanesram_ctrl`

## Requirements
- R1: From reset, `reqReady` stays low and all memory strobes stay high (inactive) for exactly `PWRUP_CYC` clock edges after `rstN` rises. `reqReady` is first high after edge number `PWRUP_CYC`.
- R2: An accepted read with at least one lane set drives `memCeN`=0, `memOeN`=0, `memWeN`=1 and `memAddr` equal to the request address for `RD_CYC` cycles, starting with the edge that accepts it. During these cycles `memLaneN[i]`=0 exactly for lanes with `reqLaneEn[i]`=1. Lane 0 covers data bits 7:0 and lane 1 covers bits 15:8.
- R3: One cycle after the last read cycle, `rdValid` is high for exactly one cycle. `rdData` then holds the memory input sampled at the end of the read window for enabled lanes, with zeros in disabled lanes.
- R4: An accepted write with at least one lane set drives `memCeN`=0, `memWeN`=0, `memOeN`=1, `memDqOe`=1, `memDqOut` equal to the request data and lane strobes per R2's encoding for `WE_CYC` cycles.
- R5: The cycle after a write pulse has all strobes high while `memDqOe` stays 1 with unchanged `memDqOut` (hold time). The driver is off in the cycle that follows.
- R6: `memDqOe` is never 1 in a cycle where `memOeN` is 0.
- R7: When the previous real access was a read, an accepted write first spends one cycle with all strobes high and the driver off, and only then starts its pulse. A write that follows a write starts on the edge that accepts it.
- R8: A request with both lane bits 0 asserts no strobe and leaves `reqReady` high. A read of this kind gives `rdValid`=1 with `rdData`=0 in the following cycle. A write of this kind changes no memory content.
- R9: `reqReady` is high only when idle after power-up, and all strobes are high whenever it is. A request presented while `reqReady` is low has no effect.
- R10: A write with one lane enabled keeps the other lane's strobe high, so that memory byte keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqLaneEn | input | LANES | Byte-lane mask, bit 0 = bits 7:0 |
| rdValid | output | 1 | One-cycle read completion pulse |
| rdData | output | DATA_W | Read result, disabled lanes zero |
| memAddr | output | ADDR_W | Memory address |
| memCeN | output | 1 | Memory select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memLaneN | output | LANES | Byte-lane strobes, active low |
| memDqOut | output | DATA_W | Data toward the memory |
| memDqOe | output | 1 | Enable of the data pad driver |
| memDqIn | input | DATA_W | Data from the memory pads |

## Verification
A state machine stuck in or skipping a state shows up at the strobe pins on the very next cycle after acceptance. Examples are a missing turnaround or recovery cycle, or a read window of the wrong length. The bench compares every strobe, every cycle of each access, against the cycle counts in the requirements. A wrong lane mask or a lost hold cycle corrupts memory silently, so each write is followed by a read-back through a bench memory model, and a bad byte appears at `rdData` one access later. A miscounted power-up counter moves the first `reqReady` edge, which the bench pins to an exact cycle.

// File: rtl/lanesram_pkg.sv
package lanesram_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_TURN,
    ST_READ,
    ST_WRITE,
    ST_WREC
  } state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic laneOn;   // lane strobes follow the stored mask
    logic drive;    // pad driver enable
    logic load;     // capture request fields
    logic capture;  // sample memory input on this edge
  } strobe_t;

endpackage

// File: rtl/lanesram_fsm.sv
module lanesram_fsm
  import lanesram_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int PWRUP_CYC = 12500,
  parameter int RD_CYC    = 2,
  parameter int WE_CYC    = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqLaneEn,
  output logic             reqReady,
  output strobe_t          strb
);

  localparam int MAX_A   = (PWRUP_CYC > RD_CYC) ? PWRUP_CYC : RD_CYC;
  localparam int MAX_CYC = (MAX_A > WE_CYC) ? MAX_A : WE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PWR_LAST = CNT_W'(PWRUP_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST  = CNT_W'(WE_CYC - 1);

  state_e           state, stateD;
  logic [CNT_W-1:0] cnt, cntD;
  logic             lastRead, lastReadD;
  logic             accept, noop;
  logic             ceNQ, weNQ, oeNQ, laneOnQ, driveQ;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;
  assign noop     = ~|reqLaneEn;

  always_comb begin
    stateD    = state;
    cntD      = cnt;
    lastReadD = lastRead;
    unique case (state)
      ST_PWR: begin
        if (cnt == PWR_LAST) begin
          stateD = ST_IDLE;
          cntD   = '0;
        end else begin
          cntD = cnt + CNT_W'(1);
        end
      end
      ST_IDLE: begin
        if (accept && !noop) begin
          cntD = '0;
          if (reqWrite) stateD = lastRead ? ST_TURN : ST_WRITE;
          else          stateD = ST_READ;
        end
      end
      ST_TURN: stateD = ST_WRITE;
      ST_READ: begin
        if (cnt == RD_LAST) begin
          stateD    = ST_IDLE;
          cntD      = '0;
          lastReadD = 1'b1;
        end else begin
          cntD = cnt + CNT_W'(1);
        end
      end
      ST_WRITE: begin
        lastReadD = 1'b0;
        if (cnt == WE_LAST) begin
          stateD = ST_WREC;
          cntD   = '0;
        end else begin
          cntD = cnt + CNT_W'(1);
        end
      end
      ST_WREC: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  // pin strobes registered from the next state: clean edges, aligned with state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PWR;
      cnt      <= '0;
      lastRead <= 1'b0;
      ceNQ     <= 1'b1;
      weNQ     <= 1'b1;
      oeNQ     <= 1'b1;
      laneOnQ  <= 1'b0;
      driveQ   <= 1'b0;
    end else begin
      state    <= stateD;
      cnt      <= cntD;
      lastRead <= lastReadD;
      ceNQ     <= !(stateD == ST_READ || stateD == ST_WRITE);
      weNQ     <= (stateD != ST_WRITE);
      oeNQ     <= (stateD != ST_READ);
      laneOnQ  <= (stateD == ST_READ || stateD == ST_WRITE);
      driveQ   <= (stateD == ST_WRITE || stateD == ST_WREC);
    end
  end

  always_comb begin
    strb.ceN     = ceNQ;
    strb.weN     = weNQ;
    strb.oeN     = oeNQ;
    strb.laneOn  = laneOnQ;
    strb.drive   = driveQ;
    strb.load    = accept;
    strb.capture = (state == ST_READ) && (cnt == RD_LAST);
  end

endmodule

// File: rtl/lanesram_dp.sv
module lanesram_dp
  import lanesram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLaneEn,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  laneQ;
  logic [DATA_W-1:0] laneBits;
  logic              noopRead;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneBits[i*LANE_W +: LANE_W] = {LANE_W{laneQ[i]}};
  end

  assign noopRead = strb.load && !reqWrite && (~|reqLaneEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      laneQ   <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        laneQ  <= reqLaneEn;
      end
      rdValid <= strb.capture || noopRead;
      if (strb.capture)  rdData <= memDqIn & laneBits;
      else if (noopRead) rdData <= '0;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memLaneN = ~(laneQ & {LANES{strb.laneOn}});

endmodule

// File: rtl/lanesram_ctrl.sv
module lanesram_ctrl
  import lanesram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LANES     = 2,
  parameter int PWRUP_CYC = 12500,
  parameter int RD_CYC    = 2,
  parameter int WE_CYC    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLaneEn,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  strobe_t strb;

  lanesram_fsm #(
    .LANES(LANES), .PWRUP_CYC(PWRUP_CYC), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC)
  ) i_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqLaneEn(reqLaneEn), .reqReady(reqReady), .strb(strb)
  );

  lanesram_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLaneEn(reqLaneEn),
    .memDqIn(memDqIn), .memAddr(memAddr), .memLaneN(memLaneN),
    .memDqOut(memDqOut), .rdValid(rdValid), .rdData(rdData)
  );

  assign memCeN  = strb.ceN;
  assign memWeN  = strb.weN;
  assign memOeN  = strb.oeN;
  assign memDqOe = strb.drive;

endmodule

// File: rtl/lanesram_ctrl_chk.sv
module lanesram_ctrl_chk #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rdValid,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [LANES-1:0]  memLaneN,
  input logic [DATA_W-1:0] memDqOut,
  input logic              memDqOe
);

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN && (&memLaneN)));

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (!memCeN && memWeN && !memDqOe));

  p_rdvalid_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  p_write_drives_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memDqOe && !memCeN && memOeN));

  p_hold_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(memWeN) && memWeN) |-> (memDqOe && $stable(memDqOut) && memCeN));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(memOeN) && memOeN) |-> !memDqOe);

  p_lanes_need_ce_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(&memLaneN) |-> !memCeN);

endmodule

bind lanesram_ctrl lanesram_ctrl_chk #(.DATA_W(DATA_W), .LANES(LANES)) i_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rdValid(rdValid),
  .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN), .memLaneN(memLaneN),
  .memDqOut(memDqOut), .memDqOe(memDqOe)
);

// File: tb/test_lanesram_ctrl.sv
`timescale 1ns/1ps
module test_lanesram_ctrl;

  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 16;
  localparam int LANES     = 2;
  localparam int PWRUP_CYC = 12500;
  localparam int RD_CYC    = 2;
  localparam int WE_CYC    = 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic [LANES-1:0]  reqLaneEn = '0;
  logic              rdValid;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] memAddr;
  logic              memCeN, memWeN, memOeN, memDqOe;
  logic [LANES-1:0]  memLaneN;
  logic [DATA_W-1:0] memDqOut;
  logic [DATA_W-1:0] memDqIn = 16'h5A5A;

  int tests = 0;
  int fails = 0;
  logic [15:0] model  [int];
  logic [15:0] shadow [int];

  always #4 clk = ~clk;

  lanesram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
    .PWRUP_CYC(PWRUP_CYC), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC)
  ) i_lanesram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqLaneEn(reqLaneEn), .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memLaneN(memLaneN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  function automatic logic [15:0] modelRd(int a);
    return model.exists(a) ? model[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] shadowRd(int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] laneMask(logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  // bench memory: sampled at the falling edge, away from the strobe updates
  always @(negedge clk) begin
    logic [15:0] cur;
    cur = modelRd(int'(memAddr));
    if (!memCeN && !memWeN && !(&memLaneN)) begin
      if (!memLaneN[0]) cur[7:0]  = memDqOut[7:0];
      if (!memLaneN[1]) cur[15:8] = memDqOut[15:8];
      model[int'(memAddr)] = cur;
    end
    if (!memCeN && !memOeN && memWeN) begin
      memDqIn[7:0]  <= memLaneN[0] ? 8'h5A : cur[7:0];
      memDqIn[15:8] <= memLaneN[1] ? 8'h5A : cur[15:8];
    end else begin
      memDqIn <= 16'h5A5A;
    end
    if (memDqOe && !memOeN) begin
      tests++; fails++;
      $display("FAIL R6: driver on with output enable low, act oe=%0b exp 1", memOeN);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(memCeN && memWeN && memOeN && (&memLaneN),
        req, "strobes idle", {memCeN, memWeN, memOeN, memLaneN}, 5'b11111);
  endtask

  task automatic powerUp();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!reqReady, "R1", "ready in reset", reqReady, 0);
    chkIdle("R1");
    rstN = 1'b1;
    // a write held during power-up must be ignored (R9)
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0042;
    reqWdata = 16'hDEAD; reqLaneEn = 2'b11;
    repeat (PWRUP_CYC - 1) @(negedge clk);
    chk(!reqReady, "R1", "ready one cycle before wait end", reqReady, 0);
    chkIdle("R9");
    reqValid = 1'b0;
    @(negedge clk);
    chk(reqReady, "R1", "ready at wait end", reqReady, 1);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] l, input bit turn);
    logic [15:0] nv;
    @(negedge clk);
    chk(reqReady, "R9", "ready before write", reqReady, 1);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d; reqLaneEn = l;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    if (turn) begin
      chkIdle("R7");
      chk(!memDqOe, "R7", "driver off in turnaround", memDqOe, 0);
      @(negedge clk);
    end
    for (int k = 0; k < WE_CYC; k++) begin
      if (k > 0) @(negedge clk);
      chk(!memCeN && !memWeN && memOeN, "R4", "write strobes",
          {memCeN, memWeN, memOeN}, 3'b001);
      chk(memLaneN == ~l, "R10", "lane strobes", memLaneN, ~l);
      chk(memDqOe && memDqOut == d && memAddr == a, "R4", "write data/addr",
          {memDqOe, memDqOut}, {1'b1, d});
      chk(!reqReady, "R9", "busy during write", reqReady, 0);
    end
    @(negedge clk);
    chkIdle("R5");
    chk(memDqOe && memDqOut == d, "R5", "hold cycle drive", {memDqOe, memDqOut}, {1'b1, d});
    @(negedge clk);
    chk(reqReady && !memDqOe, "R5", "driver released", {reqReady, memDqOe}, 2'b10);
    nv = shadowRd(int'(a));
    nv = (nv & ~laneMask(l)) | (d & laneMask(l));
    shadow[int'(a)] = nv;
  endtask

  task automatic doRead(input logic [15:0] a, input logic [1:0] l, input bit pester);
    logic [15:0] exp;
    exp = shadowRd(int'(a)) & laneMask(l);
    @(negedge clk);
    chk(reqReady, "R9", "ready before read", reqReady, 1);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqLaneEn = l;
    @(posedge clk);
    @(negedge clk);
    if (pester) begin
      reqWrite = 1'b1; reqWdata = 16'hFFFF; reqLaneEn = 2'b11;
    end else begin
      reqValid = 1'b0;
    end
    for (int k = 0; k < RD_CYC; k++) begin
      if (k > 0) @(negedge clk);
      chk(!memCeN && !memOeN && memWeN && !memDqOe, "R2", "read strobes",
          {memCeN, memOeN, memWeN, memDqOe}, 4'b0010);
      chk(memLaneN == ~l && memAddr == a, "R2", "read lanes/addr",
          {memLaneN, memAddr}, {~l, a});
      chk(!reqReady && !rdValid, "R9", "busy during read", {reqReady, rdValid}, 0);
    end
    reqValid = 1'b0;
    @(negedge clk);
    chk(rdValid && rdData == exp, "R3", "read result", {rdValid, rdData}, {1'b1, exp});
    chk(reqReady, "R9", "ready after read", reqReady, 1);
    chkIdle("R9");
    @(negedge clk);
    chk(!rdValid, "R3", "valid is a single pulse", rdValid, 0);
  endtask

  task automatic doNoop(input bit wr);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = 16'h0000;
    reqWdata = 16'h1357; reqLaneEn = 2'b00;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    chkIdle("R8");
    chk(reqReady && !memDqOe, "R8", "ready kept, no drive", {reqReady, memDqOe}, 2'b10);
    if (!wr) chk(rdValid && rdData == 16'h0, "R8", "empty read result",
                 {rdValid, rdData}, {1'b1, 16'h0});
    else     chk(!rdValid, "R8", "no valid on empty write", rdValid, 0);
    @(negedge clk);
    chkIdle("R8");
    chk(!rdValid, "R8", "no further valid", rdValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: run hung, act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    powerUp();
    doWrite(16'h1234, 16'hBEEF, 2'b11, 1'b0);   // R4 write after reset: no turnaround
    doRead (16'h1234, 2'b11, 1'b0);              // R2 R3
    doWrite(16'h1234, 16'h00AA, 2'b01, 1'b1);   // R7 after read, R10 low lane only
    doRead (16'h1234, 2'b11, 1'b0);              // R10 upper byte kept
    doWrite(16'h1234, 16'h7700, 2'b10, 1'b1);   // R10 high lane only
    doWrite(16'hFFFF, 16'h0F0F, 2'b11, 1'b0);   // R7 write after write: immediate
    doRead (16'h1234, 2'b01, 1'b0);              // R3 disabled lane reads zero
    doRead (16'hFFFF, 2'b10, 1'b1);              // R9 request while busy ignored
    doRead (16'hFFFF, 2'b11, 1'b0);              // R9 memory untouched
    doNoop(1'b0);                                // R8 empty read
    doNoop(1'b1);                                // R8 empty write
    doRead (16'h0000, 2'b11, 1'b0);              // R8 empty write stored nothing
    doWrite(16'h0000, 16'hC3C3, 2'b11, 1'b1);   // R7 turnaround survives empty requests
    doRead (16'h0000, 2'b11, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule